// File: doc/BRIEF.md
# Pause-Width Keystream Frame Transmitter

This block sends a reader-to-tag frame of up to `DATA_W` bits by gating the carrier. Each bit period opens with a short window in which the carrier is switched off. The carrier then stays on until the period ends. The information sits in the total length of the period: a long period encodes a one and a short period encodes a zero.

Before a bit is timed, its data bit is combined by XOR with the current bit of an external keystream generator. The block asks that generator for the next keystream bit once per bit period. After the last data bit, one extra carrier-off window closes the frame. The carrier is then restored, a one-cycle completion pulse is raised, and a response timer restarts from zero, so the delay until the tag answers can be read directly.

All durations are parameters counted in clock ticks. Bit end times are measured against a timestamp taken at the start of each bit on a free-running tick counter. Because of this, no timing error carries over from one bit to the next.

Top module: `pause_frame_tx`

## Requirements
- R1: Out of reset and whenever no frame is in progress, `carrier_o` is 1 and `busy_o`, `done_o` and `ks_adv_o` are 0.
- R2: Data bits are sent least significant bit first: bit period k carries `data_i[k]`, where `data_i` is the value captured on the edge that accepted the start.
- R3: Every bit period begins with exactly `PAUSE_TICKS` cycles with `carrier_o` = 0. The carrier is then 1 for the remainder of the period.
- R4: A bit period lasts `ONE_TICKS` cycles when the data bit XOR `ks_bit_i` is 1, and `ZERO_TICKS` cycles when it is 0. `ks_bit_i` is sampled on the clock edge that begins the period.
- R5: `ks_adv_o` is a one-cycle pulse in the first carrier-on cycle of each bit period, which gives exactly one pulse per data bit. The keystream source is expected to step on that clock edge.
- R6: After the last bit period, `carrier_o` is 0 for `PAUSE_TICKS` further cycles. The block then returns to idle, and `done_o` is 1 for exactly the first idle cycle.
- R7: `resp_cnt_o` is 0 in the cycle where `done_o` is 1, increases by one every cycle otherwise, and holds at 2^`TIMER_W`-1. It starts from 0 at reset.
- R8: `start_i` is acted on only when `busy_o` is 0. A start that arrives during a frame, including its trailing pause, has no effect on that frame or on the frame count.
- R9: A bit count of 0 produces only the trailing pause and the completion pulse, with no `ks_adv_o` pulse. A bit count above `DATA_W` is treated as `DATA_W`.
- R10: `busy_o` is 1 from the cycle after an accepted start through the last trailing-pause cycle. A new start applied in the completion cycle begins the next frame without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, acted on only when idle |
| data_i | input | DATA_W | Frame payload, bit 0 sent first |
| nbits_i | input | NB_W | Number of payload bits to send |
| ks_bit_i | input | 1 | Current keystream bit from the external generator |
| ks_adv_o | output | 1 | Step request to the keystream generator |
| carrier_o | output | 1 | Carrier enable, 0 during pauses |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse on the first idle cycle after a frame |
| resp_cnt_o | output | TIMER_W | Cycles since the last frame ended, saturating |

## Verification
A wrong timestamp or a wrong duration selection shows at the ports within the bit where it happens, because the carrier rises or the next pause begins one or more cycles away from the expected cycle. A corrupted shift register or bit count shows one bit period later, as a period of the wrong length or as an extra or missing `ks_adv_o` pulse. A state error in the trailing pause moves `done_o` and the response-timer restart. The bench therefore compares every output against a behavioural model on every cycle, so each of these faults is caught in the first cycle where it diverges.

// File: rtl/pft_pkg.sv
package pft_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PAUSE = 2'd1,
    ST_HOLD  = 2'd2,
    ST_TAIL  = 2'd3
  } tx_state_e;
endpackage

// File: rtl/pft_ticker.sv
module pft_ticker #(
  parameter int TICK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [TICK_W-1:0] tick_o
);
  logic [TICK_W-1:0] tick_q, tick_d;

  always_comb tick_d = tick_q + TICK_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= '0;
    else        tick_q <= tick_d;
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/pft_shifter.sv
module pft_shifter #(
  parameter int DATA_W = 32,
  parameter int NB_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [NB_W-1:0]   nbits_i,
  output logic              bit1_o,
  output logic              last_o
);
  localparam logic [NB_W-1:0] MAX_N = NB_W'(DATA_W);

  logic [DATA_W-1:0] word_q, word_d;
  logic [NB_W-1:0]   left_q, left_d;
  logic [NB_W-1:0]   n_clamped;
  logic              en;

  always_comb begin
    n_clamped = (nbits_i > MAX_N) ? MAX_N : nbits_i;
    en        = load_i | shift_i;
    word_d    = word_q;
    left_d    = left_q;
    if (load_i) begin
      word_d = data_i;
      left_d = n_clamped;
    end else if (shift_i) begin
      word_d = word_q >> 1;
      left_d = left_q - NB_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      left_q <= '0;
    end else if (en) begin
      word_q <= word_d;
      left_q <= left_d;
    end
  end

  assign bit1_o = word_q[1];
  assign last_o = (left_q == NB_W'(1));
endmodule

// File: rtl/pft_resp_timer.sv
module pft_resp_timer #(
  parameter int TIMER_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  output logic [TIMER_W-1:0] cnt_o
);
  logic [TIMER_W-1:0] cnt_q, cnt_d;
  logic               en;

  always_comb begin
    en    = clr_i | ~(&cnt_q);
    cnt_d = clr_i ? '0 : cnt_q + TIMER_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pause_frame_tx.sv
module pause_frame_tx #(
  parameter int DATA_W      = 32,
  parameter int NB_W        = $clog2(DATA_W + 1),
  parameter int PAUSE_TICKS = 4,
  parameter int ZERO_TICKS  = 10,
  parameter int ONE_TICKS   = 16,
  parameter int TIMER_W     = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic [NB_W-1:0]    nbits_i,
  input  logic               ks_bit_i,
  output logic               ks_adv_o,
  output logic               carrier_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [TIMER_W-1:0] resp_cnt_o
);
  import pft_pkg::*;

  // Periods must exceed the pause by at least two cycles so the keystream
  // step lands strictly before the next sampling edge.
  localparam int MAX_DUR = (ONE_TICKS > ZERO_TICKS) ? ONE_TICKS : ZERO_TICKS;
  localparam int TICK_W  = $clog2(MAX_DUR + 1) + 1;
  localparam logic [TICK_W-1:0] PAUSE_LAST = TICK_W'(PAUSE_TICKS - 1);
  localparam logic [TICK_W-1:0] ADV_AT     = TICK_W'(PAUSE_TICKS);
  localparam logic [TICK_W-1:0] ONE_LAST   = TICK_W'(ONE_TICKS - 1);
  localparam logic [TICK_W-1:0] ZERO_LAST  = TICK_W'(ZERO_TICKS - 1);

  tx_state_e         state_q, state_d;
  logic [TICK_W-1:0] tick, t0_q, t0_d, elapsed, end_at;
  logic              long_q, long_d, long_en;
  logic              t0_en, done_q, done_d;
  logic              sh_load, sh_shift, sh_bit1, sh_last;
  logic              resp_clr;

  pft_ticker #(.TICK_W(TICK_W)) ticker_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  pft_shifter #(.DATA_W(DATA_W), .NB_W(NB_W)) shifter_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (sh_load),
    .shift_i (sh_shift),
    .data_i  (data_i),
    .nbits_i (nbits_i),
    .bit1_o  (sh_bit1),
    .last_o  (sh_last)
  );

  pft_resp_timer #(.TIMER_W(TIMER_W)) resp_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (resp_clr),
    .cnt_o (resp_cnt_o)
  );

  // Elapsed time inside the current period, from the stored timestamp.
  always_comb begin
    elapsed = tick - t0_q;
    end_at  = long_q ? ONE_LAST : ZERO_LAST;
  end

  // Next-state and control decode.
  always_comb begin
    state_d  = state_q;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    t0_en    = 1'b0;
    long_en  = 1'b0;
    long_d   = long_q;
    done_d   = 1'b0;
    resp_clr = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          sh_load = 1'b1;
          t0_en   = 1'b1;
          if (nbits_i == '0) begin
            state_d = ST_TAIL;
          end else begin
            state_d = ST_PAUSE;
            long_en = 1'b1;
            long_d  = data_i[0] ^ ks_bit_i;
          end
        end
      end
      ST_PAUSE: begin
        if (elapsed == PAUSE_LAST) state_d = ST_HOLD;
      end
      ST_HOLD: begin
        if (elapsed == end_at) begin
          sh_shift = 1'b1;
          t0_en    = 1'b1;
          if (sh_last) begin
            state_d = ST_TAIL;
          end else begin
            state_d = ST_PAUSE;
            long_en = 1'b1;
            long_d  = sh_bit1 ^ ks_bit_i;
          end
        end
      end
      ST_TAIL: begin
        if (elapsed == PAUSE_LAST) begin
          state_d  = ST_IDLE;
          done_d   = 1'b1;
          resp_clr = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    t0_d = tick + TICK_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     t0_q <= '0;
    else if (t0_en) t0_q <= t0_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       long_q <= 1'b0;
    else if (long_en) long_q <= long_d;
  end

  assign carrier_o = (state_q != ST_PAUSE) && (state_q != ST_TAIL);
  assign busy_o    = (state_q != ST_IDLE);
  assign ks_adv_o  = (state_q == ST_HOLD) && (elapsed == ADV_AT);
  assign done_o    = done_q;
endmodule

// File: rtl/pft_checker.sv
module pft_checker #(
  parameter int TIMER_W = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start_i,
  input logic               ks_adv_o,
  input logic               carrier_o,
  input logic               busy_o,
  input logic               done_o,
  input logic [TIMER_W-1:0] resp_cnt_o
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  a_r1_idle_carrier_on: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (carrier_o && !ks_adv_o));

  a_r3_pause_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !carrier_o |-> busy_o);

  a_r5_adv_while_carrier: assert property (@(posedge clk) disable iff (!rst_n)
    ks_adv_o |-> (carrier_o && busy_o));

  a_r5_adv_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ks_adv_o |=> !ks_adv_o);

  a_r6_done_at_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && done_o) |-> ($fell(busy_o) && carrier_o));

  a_r6_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r7_resp_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (resp_cnt_o == '0));

  a_r7_resp_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !done_o && ($past(resp_cnt_o) != '1)) |->
      (resp_cnt_o == $past(resp_cnt_o) + TIMER_W'(1)));

  a_r8_start_in_hold_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && carrier_o && start_i) |=> busy_o);
endmodule

bind pause_frame_tx pft_checker #(.TIMER_W(TIMER_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .ks_adv_o   (ks_adv_o),
  .carrier_o  (carrier_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .resp_cnt_o (resp_cnt_o)
);

// File: tb/pause_frame_tx_tb_top.sv
`timescale 1ns/1ps
module pause_frame_tx_tb_top;
  localparam int DATA_W  = 32;
  localparam int NB_W    = $clog2(DATA_W + 1);
  localparam int P_T     = 4;
  localparam int Z_T     = 10;
  localparam int O_T     = 16;
  localparam int TIMER_W = 8;
  localparam int RESP_MAX = (1 << TIMER_W) - 1;

  typedef struct {
    bit    car;
    bit    bsy;
    bit    adv;
    bit    dn;
    string tag;
  } exp_t;

  logic              clk, rst_n, start_i, ks_bit_i;
  logic [DATA_W-1:0] data_i;
  logic [NB_W-1:0]   nbits_i;
  logic              ks_adv_o, carrier_o, busy_o, done_o;
  logic [TIMER_W-1:0] resp_cnt_o;

  pause_frame_tx #(
    .DATA_W(DATA_W), .NB_W(NB_W), .PAUSE_TICKS(P_T),
    .ZERO_TICKS(Z_T), .ONE_TICKS(O_T), .TIMER_W(TIMER_W)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .data_i(data_i),
    .nbits_i(nbits_i), .ks_bit_i(ks_bit_i), .ks_adv_o(ks_adv_o),
    .carrier_o(carrier_o), .busy_o(busy_o), .done_o(done_o),
    .resp_cnt_o(resp_cnt_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  bit    ks_seq [0:511];
  exp_t  q[$];
  int    checks = 0, fails = 0;
  int    model_idx = 0, drv_idx = 0;
  int    resp_exp = 0;
  bit    adv_prev = 1'b0;
  string phase = "reset";

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s (%s): act=%0d exp=%0d", tag, what, phase, act, exp);
    end
  endtask

  // Behavioural plan of one frame, one queue entry per cycle.
  task automatic plan(logic [DATA_W-1:0] d, int n);
    int neff = (n > DATA_W) ? DATA_W : n;
    for (int i = 0; i < neff; i++) begin
      bit b   = d[i] ^ ks_seq[model_idx + i];
      int dur = b ? O_T : Z_T;
      for (int c = 0; c < dur; c++) begin
        exp_t e;
        e.bsy = 1'b1;
        e.dn  = 1'b0;
        e.car = (c >= P_T);
        e.adv = (c == P_T);
        e.tag = (c < P_T) ? "R3" : "R4";
        q.push_back(e);
      end
    end
    model_idx += neff;
    for (int c = 0; c < P_T; c++) begin
      exp_t e;
      e.car = 1'b0; e.bsy = 1'b1; e.adv = 1'b0; e.dn = 1'b0; e.tag = "R6";
      q.push_back(e);
    end
    begin
      exp_t e;
      e.car = 1'b1; e.bsy = 1'b0; e.adv = 1'b0; e.dn = 1'b1; e.tag = "R6";
      q.push_back(e);
    end
  endtask

  // One cycle: compare at the falling edge, then drive inputs for the next edge.
  task automatic cyc(bit st, logic [DATA_W-1:0] d, int n);
    exp_t e;
    @(negedge clk);
    if (adv_prev) begin
      drv_idx++;
      ks_bit_i = ks_seq[drv_idx];
    end
    adv_prev = ks_adv_o;
    if (q.size() > 0) e = q.pop_front();
    else begin
      e.car = 1'b1; e.bsy = 1'b0; e.adv = 1'b0; e.dn = 1'b0; e.tag = "R1";
    end
    if (e.dn) resp_exp = 0;
    else if (resp_exp < RESP_MAX) resp_exp++;
    chk(e.tag, "carrier", int'(carrier_o), int'(e.car));
    chk("R10", "busy", int'(busy_o), int'(e.bsy));
    chk("R5", "ks_adv", int'(ks_adv_o), int'(e.adv));
    chk("R6", "done", int'(done_o), int'(e.dn));
    chk("R7", "resp_cnt", int'(resp_cnt_o), resp_exp);
    start_i = st;
    data_i  = d;
    nbits_i = NB_W'(n);
    if (st && q.size() == 0) plan(d, n);
  endtask

  task automatic run_to_idle();
    while (q.size() > 0) cyc(1'b0, '0, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: act=hung exp=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [8:0] lfsr = 9'h1A5;
    for (int i = 0; i < 512; i++) begin
      ks_seq[i] = lfsr[0];
      lfsr = {lfsr[0] ^ lfsr[4], lfsr[8:1]};
    end
    rst_n = 1'b0; start_i = 1'b0; data_i = '0; nbits_i = '0;
    ks_bit_i = ks_seq[0];
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "reset carrier", int'(carrier_o), 1);
    chk("R1", "reset busy", int'(busy_o), 0);
    chk("R1", "reset done", int'(done_o), 0);
    chk("R1", "reset adv", int'(ks_adv_o), 0);
    chk("R7", "reset resp", int'(resp_cnt_o), 0);
    rst_n = 1'b1;
    resp_exp = 0;
    repeat (4) cyc(1'b0, '0, 0);

    phase = "R2 R4 byte pattern";
    cyc(1'b1, 32'h0000_00A5, 8);
    run_to_idle();

    phase = "R2 R4 full word";
    cyc(1'b1, 32'hDEAD_BEEF, 32);
    run_to_idle();

    phase = "R9 zero-length frame";
    cyc(1'b1, 32'hFFFF_FFFF, 0);
    run_to_idle();

    phase = "R9 count clamp";
    cyc(1'b1, 32'hFFFF_0000, 40);
    run_to_idle();

    phase = "R8 start while busy";
    cyc(1'b1, 32'h0000_0013, 5);
    repeat (7) cyc(1'b0, '0, 0);
    cyc(1'b1, 32'h0000_FFFF, 16);
    repeat (20) cyc(1'b0, '0, 0);
    cyc(1'b1, 32'h0000_0000, 3);
    while (q.size() > 2) cyc(1'b0, '0, 0);
    cyc(1'b1, 32'h0000_0001, 1);   // during trailing pause
    run_to_idle();

    phase = "R10 back-to-back";
    cyc(1'b1, 32'h0000_0006, 3);
    while (q.size() > 1) cyc(1'b0, '0, 0);
    cyc(1'b1, 32'h0000_0001, 1);
    run_to_idle();

    phase = "R7 response saturation";
    repeat (RESP_MAX + 20) cyc(1'b0, '0, 0);

    phase = "R2 single bit after saturation";
    cyc(1'b1, 32'h0000_0001, 1);
    run_to_idle();
    repeat (5) cyc(1'b0, '0, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule